// File: doc/BRIEF.md
# Packed Decimal to Binary Integer Converter

This block translates between a ten-byte signed packed-decimal value and a 64-bit two's-complement integer, in either direction. A single start strobe launches one conversion. The direction input chooses between decoding a packed value into binary (a load) and encoding a binary integer into packed form (a store). The work is sequential. A load folds one decimal digit per clock into a running binary total using multiply-by-ten accumulation. A store peels off one decimal digit per clock by dividing by ten.

The packed layout is fixed and the block's behaviour depends on it. Bytes 0 to 8 each carry two digits, and the lower nibble is the lower-weight digit of the pair. Weights rise tenfold per nibble from byte 0 upward. Byte 9 carries the sign in bit 7, where 1 means negative. On a load only, its low nibble serves as a nineteenth, top digit. The binary side of a store is taken to hold an integer already, so no rounding takes place. The results stay on the outputs from the done pulse until the next accepted start.

Top module: `bcd_conv`

## Requirements
- R1: A load (toBinary=1) returns on intOut the two's-complement value of sum(d_i * 10^i). Here d_(2k) is bits [8k+3:8k] and d_(2k+1) is bits [8k+7:8k+4] of packedIn for k=0..8, and d_18 is bits [75:72]. The value is negated when bit 79 is 1.
- R2: On a load, bits [78:76] of packedIn have no effect on any output.
- R3: On a load, any digit nibble above 9 sets badDigit, and intOut is still formed from the raw nibble values (modulo 2^64).
- R4: A load of a packed zero with bit 79 set gives intOut=0 and signOut=1.
- R5: A store (toBinary=0) with |intIn| at most 10^18-1 writes the decimal digits of |intIn| into packedOut with the same nibble placement as R1. It sets bit 79 to intIn[63] and sets bits [78:72] to zero.
- R6: A store with |intIn| of 10^18 or more sets overflow and writes packedOut with bytes 9, 8 and 7 equal to 0xFF and bytes 0 to 6 equal to 0xC0.
- R7: done is a one-cycle pulse. It rises 19 clocks after the edge that accepts a load, and 18 clocks after the edge that accepts a store.
- R8: busy is high from the accepting edge until done rises. A start seen while busy is ignored.
- R9: After reset, busy, done, badDigit, overflow, signOut, intOut and packedOut are all zero.
- R10: Each accepted start clears both flags. A store never sets badDigit, and a load never sets overflow. signOut gives the sign bit of the operand that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion when idle |
| toBinary | input | 1 | 1 = packed to binary, 0 = binary to packed |
| packedIn | input | 80 | Packed-decimal operand for a load |
| intIn | input | 64 | Two's-complement operand for a store |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| intOut | output | 64 | Binary result of a load |
| signOut | output | 1 | Sign of the accepted operand |
| packedOut | output | 80 | Packed result of a store |
| badDigit | output | 1 | Load met a nibble above 9 |
| overflow | output | 1 | Store magnitude exceeded 18 digits |

## Verification
The bench targets three kinds of corner case.

The first is the magnitude limit. Both 10^18-1 and 10^18 are stored, and so is the most negative integer, whose magnitude has no positive two's-complement form. A comparator that is off by one would pack a 19th digit or flag a legal value. A naive absolute value would give a wrong digit string.

The second is the top byte. Loads are applied with the spare sign-byte bits set, with negative zero, and with digits above nine. A decoder that let those bits through, dropped the raw nibble value, or lost the sign of a zero result would return the wrong intOut or signOut.

The third is control. Every clock is checked for busy and done, and a second start is injected mid-conversion. A controller that restarted, or that used the wrong step count for one direction, would show up as a shifted or corrupted done.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

  // Strobes from the sequencer to the digit datapath.
  typedef struct packed {
    logic capture;    // latch operands, clear working state
    logic dirLoad;    // direction of the captured operation
    logic stepLoad;   // fold one decimal digit into the binary total
    logic stepStore;  // extract one decimal digit from the magnitude
  } dpCmd_t;

  // Largest magnitude representable with the given number of decimal digits.
  function automatic logic [63:0] decLimit(input int digits);
    logic [63:0] v;
    v = 64'd1;
    for (int i = 0; i < digits; i++) v = v * 64'd10;
    return v - 64'd1;
  endfunction

endpackage

// File: rtl/bcd_conv_ctrl.sv
module bcd_conv_ctrl
  import bcd_conv_pkg::*;
#(
  parameter int LOAD_STEPS  = 19,
  parameter int STORE_STEPS = 18
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   toBinary,
  output dpCmd_t cmd,
  output logic   busy,
  output logic   done
);
  localparam int CNT_W = $clog2(LOAD_STEPS + 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t           state;
  logic [CNT_W-1:0] stepCnt;
  logic             dirLoad;

  always_comb begin
    cmd.capture   = (state == ST_IDLE) && start;
    cmd.dirLoad   = (state == ST_IDLE) ? toBinary : dirLoad;
    cmd.stepLoad  = (state == ST_RUN) && dirLoad;
    cmd.stepStore = (state == ST_RUN) && !dirLoad;
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      dirLoad <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          dirLoad <= toBinary;
          stepCnt <= toBinary ? CNT_W'(LOAD_STEPS - 1) : CNT_W'(STORE_STEPS - 1);
        end
        ST_RUN: if (stepCnt == '0) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          stepCnt <= stepCnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent latency monitor for the completion check.
  logic [CNT_W-1:0] latCnt;
  logic             latDir;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latCnt <= '0;
      latDir <= 1'b0;
    end else if (cmd.capture) begin
      latCnt <= '0;
      latDir <= toBinary;
    end else if (busy) begin
      latCnt <= latCnt + CNT_W'(1);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                        // R7
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (latCnt == (latDir ? CNT_W'(LOAD_STEPS) : CNT_W'(STORE_STEPS)))); // R7
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stepCnt != '0) |=> (busy && stepCnt == $past(stepCnt) - CNT_W'(1))); // R8

endmodule

// File: rtl/bcd_conv_dp.sv
module bcd_conv_dp
  import bcd_conv_pkg::*;
#(
  parameter int INT_W    = 64,
  parameter int PK_BYTES = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpCmd_t             cmd,
  input  logic [PK_BYTES*8-1:0] packedIn,
  input  logic [INT_W-1:0]   intIn,
  output logic [INT_W-1:0]   intOut,
  output logic               signOut,
  output logic [PK_BYTES*8-1:0] packedOut,
  output logic               badDigit,
  output logic               overflow
);
  localparam int PK_W      = PK_BYTES * 8;
  localparam int PAIR_W    = (PK_BYTES - 1) * 8;       // digit-pair bytes
  localparam int LOAD_W    = PAIR_W + 4;               // plus top nibble
  localparam int TOP_NIB   = PK_W - 5;                 // msb of top digit
  localparam logic [INT_W-1:0] MAX_MAG = INT_W'(decLimit(2 * (PK_BYTES - 1)));

  logic [LOAD_W-1:0] digitsReg;
  logic [INT_W-1:0]  accReg;
  logic [INT_W-1:0]  magReg;
  logic [PAIR_W-1:0] pkReg;
  logic              signReg;

  logic [3:0]       curNib;
  logic [INT_W-1:0] absIn, quot, remW;
  logic [PK_W-1:0]  indefPat;

  assign curNib = digitsReg[LOAD_W-1 -: 4];
  assign absIn  = intIn[INT_W-1] ? (~intIn + INT_W'(1)) : intIn;
  assign quot   = magReg / INT_W'(10);
  assign remW   = magReg - quot * INT_W'(10);

  // Overflow pattern: top three bytes all ones, the rest 0xC0.
  for (genvar b = 0; b < PK_BYTES; b++) begin : g_indef
    assign indefPat[b*8 +: 8] = (b >= PK_BYTES - 3) ? 8'hFF : 8'hC0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      digitsReg <= '0;
      accReg    <= '0;
      magReg    <= '0;
      pkReg     <= '0;
      signReg   <= 1'b0;
      badDigit  <= 1'b0;
      overflow  <= 1'b0;
    end else if (cmd.capture) begin
      accReg    <= '0;
      pkReg     <= '0;
      badDigit  <= 1'b0;
      digitsReg <= {packedIn[TOP_NIB -: 4], packedIn[PAIR_W-1:0]};
      magReg    <= absIn;
      signReg   <= cmd.dirLoad ? packedIn[PK_W-1] : intIn[INT_W-1];
      overflow  <= !cmd.dirLoad && (absIn > MAX_MAG);
    end else if (cmd.stepLoad) begin
      accReg    <= accReg * INT_W'(10) + INT_W'(curNib);
      digitsReg <= digitsReg << 4;
      badDigit  <= badDigit | (curNib > 4'd9);
    end else if (cmd.stepStore) begin
      pkReg  <= {remW[3:0], pkReg[PAIR_W-1:4]};
      magReg <= quot;
    end
  end

  assign intOut    = signReg ? (~accReg + INT_W'(1)) : accReg;
  assign signOut   = signReg;
  assign packedOut = overflow ? indefPat : {signReg, {(PK_W - PAIR_W - 1){1'b0}}, pkReg};

  AST_LOAD_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.stepLoad |=> accReg >= $past(accReg));                       // R1
  AST_STORE_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.stepStore |=> magReg <= $past(magReg));                      // R5
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (badDigit && !cmd.capture) |=> badDigit);                        // R3

endmodule

// File: rtl/bcd_conv.sv
module bcd_conv
  import bcd_conv_pkg::*;
#(
  parameter int INT_W    = 64,
  parameter int PK_BYTES = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  toBinary,
  input  logic [PK_BYTES*8-1:0] packedIn,
  input  logic [INT_W-1:0]      intIn,
  output logic                  busy,
  output logic                  done,
  output logic [INT_W-1:0]      intOut,
  output logic                  signOut,
  output logic [PK_BYTES*8-1:0] packedOut,
  output logic                  badDigit,
  output logic                  overflow
);
  localparam int LOAD_STEPS  = 2 * (PK_BYTES - 1) + 1;
  localparam int STORE_STEPS = 2 * (PK_BYTES - 1);

  dpCmd_t cmd;

  bcd_conv_ctrl #(.LOAD_STEPS(LOAD_STEPS), .STORE_STEPS(STORE_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .toBinary(toBinary),
    .cmd(cmd), .busy(busy), .done(done)
  );

  bcd_conv_dp #(.INT_W(INT_W), .PK_BYTES(PK_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .packedIn(packedIn), .intIn(intIn),
    .intOut(intOut), .signOut(signOut), .packedOut(packedOut),
    .badDigit(badDigit), .overflow(overflow)
  );

  AST_OVF_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                 // R8

endmodule

// File: tb/bcd_conv_tb.sv
module bcd_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        toBinary = 1'b0;
  logic [79:0] packedIn = '0;
  logic [63:0] intIn = '0;
  logic        busy, done, signOut, badDigit, overflow;
  logic [63:0] intOut;
  logic [79:0] packedOut;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  bcd_conv u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .toBinary(toBinary),
    .packedIn(packedIn), .intIn(intIn), .busy(busy), .done(done),
    .intOut(intOut), .signOut(signOut), .packedOut(packedOut),
    .badDigit(badDigit), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Packed image of a magnitude, digit i placed by weight 10^i.
  function automatic logic [79:0] mkPk(input bit neg, input longint unsigned v);
    logic [79:0] p = '0;
    for (int i = 0; i < 19; i++) begin
      logic [3:0] d = 4'(v % 10);
      v = v / 10;
      if (i < 18) p[4*i +: 4] = d; else p[75:72] = d;
    end
    p[79] = neg;
    return p;
  endfunction

  task automatic runOp(input string tag, input bit ld, input logic [79:0] pin,
                       input logic [63:0] iin, input bit poke);
    int n = ld ? 19 : 18;
    longint unsigned m = 0, pw = 1, mag;
    bit bad = 0, ovf;
    logic [63:0] expInt;
    logic [79:0] expPk;
    for (int i = 0; i < 19; i++) begin
      longint unsigned d = (i < 18) ? longint'(pin[4*i +: 4]) : longint'(pin[75:72]);
      if (d > 9) bad = 1;
      m += d * pw;
      pw *= 10;
    end
    expInt = pin[79] ? -m : m;
    mag = iin[63] ? -iin : iin;
    ovf = mag > 64'd999999999999999999;
    expPk = ovf ? {8'hFF, 8'hFF, 8'hFF, {7{8'hC0}}} : mkPk(iin[63], mag);

    @(negedge clk);
    toBinary = ld; packedIn = pin; intIn = iin; start = 1'b1;
    for (int c = 0; c <= n + 1; c++) begin
      @(negedge clk);
      if (c == 0) start = 1'b0;
      if (poke && c == 5) begin
        start = 1'b1; toBinary = ~ld; packedIn = ~pin; intIn = ~iin;
      end
      if (poke && c == 6) begin
        start = 1'b0; toBinary = ld; packedIn = pin; intIn = iin;
      end
      if (c < n) begin
        chk("R8 busy", 80'(busy), 80'(1));
        chk("R7 done low", 80'(done), 80'(0));
      end else if (c == n) begin
        chk("R7 done", 80'(done), 80'(1));
        chk("R8 busy drop", 80'(busy), 80'(0));
        if (ld) begin
          chk(tag, 80'(intOut), 80'(expInt));
          chk({tag, " sign"}, 80'(signOut), 80'(pin[79]));
          chk("R3 badDigit", 80'(badDigit), 80'(bad));
          chk("R10 no ovf on load", 80'(overflow), 80'(0));
        end else begin
          chk(tag, packedOut, expPk);
          chk("R6 overflow flag", 80'(overflow), 80'(ovf));
          chk("R10 no bad on store", 80'(badDigit), 80'(0));
          chk("R10 sign", 80'(signOut), 80'(iin[63]));
        end
      end else begin
        chk("R7 pulse", 80'(done), 80'(0));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 busy", 80'(busy), 80'(0));
    chk("R9 done", 80'(done), 80'(0));
    chk("R9 intOut", 80'(intOut), 80'(0));
    chk("R9 packedOut", packedOut, 80'(0));
    chk("R9 flags", 80'({badDigit, overflow, signOut}), 80'(0));

    runOp("R1 load pos", 1, mkPk(0, 64'd1123456789012345678), '0, 0);
    runOp("R1 load neg", 1, mkPk(1, 64'd987654321098765432), '0, 0);
    runOp("R2 spare bits", 1, mkPk(0, 64'd4200000000000000017) | (80'h7 << 76), '0, 0);
    runOp("R3 bad digit", 1, 80'h00_0000000000000000_00FA, '0, 0);
    runOp("R3 all F", 1, {8'h0F, {9{8'hFF}}}, '0, 0);
    runOp("R4 neg zero", 1, {8'h80, 72'h0}, '0, 0);
    runOp("R5 store pos", 0, '0, 64'd123456789012345678, 0);
    runOp("R5 store neg", 0, '0, -64'd5550001, 0);
    runOp("R5 store zero", 0, '0, 64'd0, 0);
    runOp("R6 max legal", 0, '0, 64'd999999999999999999, 0);
    runOp("R6 just over", 0, '0, 64'd1000000000000000000, 0);
    runOp("R6 most neg", 0, '0, 64'h8000000000000000, 0);
    runOp("R8 ignored start load", 1, mkPk(1, 64'd31415926535), 64'd77, 1);
    runOp("R8 ignored start store", 0, 80'h12345, -64'd271828, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule